// File: doc/BRIEF.md
# Regulator Start-Up and Fault Sequencer

This block decides the operating mode of a switching buck regulator controller. It follows the supply through a hysteretic power-on reset and waits for an enable pin and a usable voltage-ID code. It then runs a soft-start, during which a rising ramp caps the duty command, and releases control to the feedback loop when the ramp completes. The analog comparators, the voltage DAC and the loop filter sit outside the block and connect through single-bit flags and the ramp bus.

Once soft-start is over, an over-voltage trip puts the converter into a latched fault. In this fault the high-side switch stays off and the low-side switch stays on. The fault does not clear when the trip flag drops. It clears in only three ways: the supply falls back into reset, the enable pin goes low, or the shutdown code is applied to the voltage-ID inputs. Each of these leads to a fresh soft-start from zero.

Top module: `vreg_startup_seq`

## Requirements
- R1: After reset the block is in power-on reset with all outputs at 0. It leaves power-on reset only at a clock edge where sup_above_i is 1. Until then, enable and code have no effect.
- R2: While in power-on reset, drv_en_o and force_low_o are both 0. In any other mode, sup_below_i at 1 returns the block to power-on reset at the next edge.
- R3: From idle, soft-start begins at the next edge only if out_en_i is 1 and vid_i differs from the shutdown code, which is all ones (5'b11111). The shutdown code keeps the block in idle.
- R4: ss_active_o stays at 1 for exactly 2^SS_LOG2 edges on which cyc_tick_i is 1. After the edge carrying the last of those ticks, the block enters run.
- R5: During soft-start, ramp_o equals floor(count * (2^DUTY_W - 1) / 2^SS_LOG2), where count is the number of ticks seen so far in this soft-start. In run, ramp_o is all ones. In every other mode it is 0.
- R6: ovp_trip_i has no effect outside run. In particular, during soft-start it neither sets force_low_o nor stops the ramp.
- R7: In run, ovp_trip_i at 1 enters the fault mode at the next edge: drv_en_o=1, force_low_o=1, ramp_o=0. The fault persists after ovp_trip_i returns to 0.
- R8: The fault clears to idle on out_en_i=0 or on vid_i=5'b11111, and to power-on reset on sup_below_i=1. After the clear, soft-start begins again with count 0.
- R9: out_en_i=0 in soft-start or run sends the block to idle at the next edge, with drv_en_o=0.
- R10: The shutdown code on vid_i during soft-start or run sends the block to idle at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sup_above_i | input | 1 | Supply above the rising threshold |
| sup_below_i | input | 1 | Supply below the falling threshold |
| out_en_i | input | 1 | Output enable pin |
| vid_i | input | VID_W | Voltage-ID code, all ones = shutdown |
| ovp_trip_i | input | 1 | Output above the over-voltage trip point |
| cyc_tick_i | input | 1 | One pulse per switching cycle |
| drv_en_o | output | 1 | Gate drivers enabled |
| force_low_o | output | 1 | High side held off, low side held on |
| ramp_o | output | DUTY_W | Soft-start duty clamp |
| ss_active_o | output | 1 | Soft-start in progress |

## Verification
The bench builds the block with SS_LOG2=5 and DUTY_W=8, so one soft-start takes 32 ticks instead of 2048. This lets the run reach the fault latch, all three ways of clearing it, and the restarted soft-start many times over. With DUTY_W wider than the counter, the ramp scaling gives non-trivial, uneven steps, and each of them is compared with the model. Sparse tick patterns test that the counter advances only on ticks, and the run-length measurement checks the exact tick count.

// File: rtl/vreg_seq_pkg.sv
package vreg_seq_pkg;
  typedef enum logic [2:0] {
    MODE_POR  = 3'd0,
    MODE_IDLE = 3'd1,
    MODE_SOFT = 3'd2,
    MODE_RUN  = 3'd3,
    MODE_OVP  = 3'd4
  } seq_mode_e;
endpackage

// File: rtl/vreg_ss_counter.sv
module vreg_ss_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        count_q <= '0;
    else if (!soft_i)   count_q <= '0;
    else if (tick_i)    count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;
  assign done_o  = soft_i && tick_i && (count_q == CNT_LAST);

  assert_count_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_i |=> (count_q == '0));
  assert_count_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_i && !tick_i) |=> $stable(count_q));
endmodule

// File: rtl/vreg_ramp_scale.sv
module vreg_ramp_scale #(
  parameter int CNT_W  = 11,
  parameter int DUTY_W = 8
) (
  input  logic [CNT_W-1:0]  count_i,
  input  logic              soft_i,
  input  logic              full_i,
  output logic [DUTY_W-1:0] ramp_o
);
  localparam int PROD_W = CNT_W + DUTY_W;
  localparam logic [PROD_W-1:0] DUTY_MAX = PROD_W'((64'd1 << DUTY_W) - 64'd1);

  always_comb begin
    if (full_i)      ramp_o = '1;
    else if (soft_i) ramp_o = DUTY_W'((PROD_W'(count_i) * DUTY_MAX) >> CNT_W);
    else             ramp_o = '0;
  end

  always_comb begin
    if (!soft_i && !full_i) assert_ramp_zero_R5: assert (ramp_o == '0);
  end
endmodule

// File: rtl/vreg_mode_fsm.sv
module vreg_mode_fsm
  import vreg_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sup_above_i,
  input  logic      sup_below_i,
  input  logic      out_en_i,
  input  logic      code_ok_i,
  input  logic      ovp_trip_i,
  input  logic      ss_done_i,
  output seq_mode_e mode_o
);
  seq_mode_e mode_q, mode_d;
  logic      stay_on;

  assign stay_on = out_en_i && code_ok_i;

  always_comb begin
    mode_d = mode_q;
    if (mode_q != MODE_POR && sup_below_i) begin
      mode_d = MODE_POR;
    end else begin
      case (mode_q)
        MODE_POR:  if (sup_above_i) mode_d = MODE_IDLE;
        MODE_IDLE: if (stay_on)     mode_d = MODE_SOFT;
        MODE_SOFT: begin
          if (!stay_on)       mode_d = MODE_IDLE;
          else if (ss_done_i) mode_d = MODE_RUN;
        end
        MODE_RUN: begin
          if (!stay_on)        mode_d = MODE_IDLE;
          else if (ovp_trip_i) mode_d = MODE_OVP;
        end
        MODE_OVP:  if (!stay_on)    mode_d = MODE_IDLE;
        default:                    mode_d = MODE_POR;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_POR;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  assert_por_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_POR && !sup_above_i) |=> (mode_q == MODE_POR));
  assert_por_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_POR && sup_below_i) |=> (mode_q == MODE_POR));
  assert_ovp_armed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_RUN && mode_q != MODE_OVP) |=> (mode_q != MODE_OVP));
  assert_ovp_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_OVP && stay_on && !sup_below_i) |=> (mode_q == MODE_OVP));
  assert_oe_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_en_i && !sup_below_i && (mode_q == MODE_SOFT || mode_q == MODE_RUN || mode_q == MODE_OVP))
    |=> (mode_q == MODE_IDLE));
endmodule

// File: rtl/vreg_startup_seq.sv
module vreg_startup_seq
  import vreg_seq_pkg::*;
#(
  parameter int SS_LOG2 = 11,
  parameter int DUTY_W  = 8,
  parameter int VID_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sup_above_i,
  input  logic              sup_below_i,
  input  logic              out_en_i,
  input  logic [VID_W-1:0]  vid_i,
  input  logic              ovp_trip_i,
  input  logic              cyc_tick_i,
  output logic              drv_en_o,
  output logic              force_low_o,
  output logic [DUTY_W-1:0] ramp_o,
  output logic              ss_active_o
);
  localparam logic [VID_W-1:0] VID_OFF = '1;

  seq_mode_e          mode;
  logic               code_ok, ss_done, in_soft, in_run;
  logic [SS_LOG2-1:0] ss_count;

  assign code_ok = (vid_i != VID_OFF);
  assign in_soft = (mode == MODE_SOFT);
  assign in_run  = (mode == MODE_RUN);

  vreg_mode_fsm i_fsm (
    .clk_i, .rst_ni, .sup_above_i, .sup_below_i, .out_en_i,
    .code_ok_i (code_ok),
    .ovp_trip_i,
    .ss_done_i (ss_done),
    .mode_o    (mode)
  );

  vreg_ss_counter #(.CNT_W(SS_LOG2)) i_cnt (
    .clk_i, .rst_ni,
    .soft_i  (in_soft),
    .tick_i  (cyc_tick_i),
    .count_o (ss_count),
    .done_o  (ss_done)
  );

  vreg_ramp_scale #(.CNT_W(SS_LOG2), .DUTY_W(DUTY_W)) i_ramp (
    .count_i (ss_count),
    .soft_i  (in_soft),
    .full_i  (in_run),
    .ramp_o  (ramp_o)
  );

  assign drv_en_o    = in_soft || in_run || (mode == MODE_OVP);
  assign force_low_o = (mode == MODE_OVP);
  assign ss_active_o = in_soft;

  assert_fault_drv_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_low_o |-> (drv_en_o && !ss_active_o && ramp_o == '0));
  assert_fault_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(force_low_o) |-> $past(drv_en_o && !ss_active_o && ovp_trip_i));
  assert_ss_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_active_o && !cyc_tick_i) |=> (ss_active_o || !drv_en_o));
endmodule

// File: tb/test_vreg_startup_seq.sv
module test_vreg_startup_seq;
  localparam int SS_LOG2 = 5;
  localparam int DUTY_W  = 8;
  localparam int VID_W   = 5;
  localparam int NTICK   = 1 << SS_LOG2;
  localparam int DMAXV   = (1 << DUTY_W) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sup_above_i = 1'b0, sup_below_i = 1'b0, out_en_i = 1'b0;
  logic ovp_trip_i = 1'b0, cyc_tick_i = 1'b0;
  logic [VID_W-1:0] vid_i = 5'b01010;
  logic drv_en_o, force_low_o, ss_active_o;
  logic [DUTY_W-1:0] ramp_o;

  int n_chk = 0, n_fail = 0, wd = 0;
  bit done = 0;
  int m_mode = 0;  // 0 por 1 idle 2 soft 3 run 4 fault
  int m_cnt = 0;

  always #4 clk = ~clk;

  vreg_startup_seq #(.SS_LOG2(SS_LOG2), .DUTY_W(DUTY_W), .VID_W(VID_W)) i_vreg_startup_seq (
    .clk_i(clk), .rst_ni, .sup_above_i, .sup_below_i, .out_en_i, .vid_i,
    .ovp_trip_i, .cyc_tick_i, .drv_en_o, .force_low_o, .ramp_o, .ss_active_o
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; m_cnt = 0;
    end else begin
      bit on;
      on = out_en_i && (vid_i != 5'b11111);
      if (m_mode != 0 && sup_below_i) begin m_mode = 0; m_cnt = 0; end
      else if (m_mode == 0) begin if (sup_above_i) m_mode = 1; end
      else if (m_mode == 1) begin if (on) begin m_mode = 2; m_cnt = 0; end end
      else if (!on) begin m_mode = 1; m_cnt = 0; end
      else if (m_mode == 2) begin
        if (cyc_tick_i) begin
          if (m_cnt == NTICK - 1) begin m_mode = 3; m_cnt = 0; end
          else m_cnt++;
        end
      end
      else if (m_mode == 3) begin if (ovp_trip_i) m_mode = 4; end
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      int er;
      er = (m_mode == 2) ? (m_cnt * DMAXV) / NTICK : (m_mode == 3) ? DMAXV : 0;
      chk("R2 drv_en", drv_en_o, (m_mode >= 2) ? 1 : 0);
      chk("R7 force_low", force_low_o, (m_mode == 4) ? 1 : 0);
      chk("R4 ss_active", ss_active_o, (m_mode == 2) ? 1 : 0);
      chk("R5 ramp", ramp_o, er);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=<100000", wd);
      finish_run();
    end
  end

  task automatic cycles(int n, int per);
    for (int i = 0; i < n; i++) begin
      cyc_tick_i = (per > 0) && (i % per == 0);
      @(posedge clk); #1;
    end
    cyc_tick_i = 1'b0;
  endtask

  task automatic por_exit();
    sup_above_i = 1'b1; cycles(1, 0); sup_above_i = 1'b0;
  endtask

  initial begin
    out_en_i = 1'b1;
    #13;
    chk("R1 reset drv", drv_en_o, 0);
    chk("R1 reset ramp", ramp_o, 0);
    chk("R1 reset ss", ss_active_o, 0);
    @(posedge clk); #1; rst_ni = 1'b1;
    cycles(5, 1);
    chk("R1 no exit without above", ss_active_o, 0);
    vid_i = 5'b11111; por_exit(); cycles(4, 0);
    chk("R3 shutdown code idle", drv_en_o, 0);
    vid_i = 5'b00111; cycles(2, 0);
    chk("R3 soft start", ss_active_o, 1);
    chk("R5 ramp starts at 0", ramp_o, 0);
    ovp_trip_i = 1'b1; cycles(16, 2);
    chk("R6 ovp ignored in soft", force_low_o, 0);
    chk("R6 soft continues", ss_active_o, 1);
    ovp_trip_i = 1'b0; cycles(40, 1);
    chk("R4 run reached", ss_active_o, 0);
    chk("R5 ramp full", ramp_o, DMAXV);
    ovp_trip_i = 1'b1; cycles(1, 0); ovp_trip_i = 1'b0; cycles(6, 0);
    chk("R7 fault latched", force_low_o, 1);
    chk("R7 drivers on", drv_en_o, 1);
    out_en_i = 1'b0; cycles(2, 0);
    chk("R8 oe clears fault", force_low_o + drv_en_o, 0);
    out_en_i = 1'b1; cycles(2, 0);
    chk("R8 restart soft", ss_active_o, 1);
    chk("R8 restart ramp 0", ramp_o, 0);
    cycles(40, 1); ovp_trip_i = 1'b1; cycles(1, 0); ovp_trip_i = 1'b0;
    vid_i = 5'b11111; cycles(3, 0);
    chk("R8 code clears fault", drv_en_o, 0);
    vid_i = 5'b01111; cycles(2, 0);
    chk("R8 code restart", ss_active_o, 1);
    cycles(40, 1); ovp_trip_i = 1'b1; cycles(3, 0); ovp_trip_i = 1'b0;
    sup_below_i = 1'b1; cycles(1, 0); sup_below_i = 1'b0; cycles(4, 0);
    chk("R8 supply clears fault", drv_en_o, 0);
    chk("R2 held in por", ss_active_o, 0);
    por_exit(); cycles(1, 0);
    chk("R2 por exit restart", ss_active_o, 1);
    begin
      int n = 0;
      while (ss_active_o && n < 100) begin
        cyc_tick_i = 1'b1; @(posedge clk); #1; n++;
      end
      cyc_tick_i = 1'b0;
      chk("R4 soft length", n, NTICK);
    end
    out_en_i = 1'b0; cycles(2, 0); out_en_i = 1'b1; cycles(6, 1);
    out_en_i = 1'b0; cycles(2, 0);
    chk("R9 oe low in soft", drv_en_o + ss_active_o, 0);
    out_en_i = 1'b1; cycles(2, 0);
    vid_i = 5'b11111; cycles(2, 0);
    chk("R10 code off in soft", drv_en_o, 0);
    vid_i = 5'b00000; cycles(45, 1);
    chk("R4 run again", drv_en_o, 1);
    vid_i = 5'b11111; cycles(2, 0);
    chk("R10 code off in run", drv_en_o, 0);
    vid_i = 5'b00000; cycles(45, 1);
    out_en_i = 1'b0; cycles(2, 0);
    chk("R9 oe low in run", drv_en_o, 0);
    out_en_i = 1'b1; cycles(10, 3);
    sup_below_i = 1'b1; cycles(1, 0); sup_below_i = 1'b0; cycles(2, 0);
    chk("R2 below in soft", drv_en_o, 0);
    finish_run();
  end
endmodule